// File: doc/BRIEF.md
# Ethernet Receive Frame Status Accumulator

This block follows one Ethernet frame through the receive path and condenses everything that happened during it into a 32-bit descriptor status word. While the frame is open, it counts received bytes and remembers error events. These events are PHY receive errors, bytes that arrived while the receive FIFO was full, FIFO parity faults and control-frame detection. When the frame closes, it merges these records with the end-of-frame checks (CRC result and dribble bits) and with the control settings. The result is registered and announced by a one-cycle valid pulse.

A frame opens on the cycle `sof` is high. It closes either normally on `eof`, or early when software withdraws `rx_enable` or raises `halt_now`. An early close marks the word as halted and skips the CRC and dribble checks. The word carries a summary interrupt bit. The same decision drives an `irq` pulse that lines up with the valid strobe.

Top module: `rx_frame_status`

## Requirements
- R1: The status word appears on `status_word`, and `status_vld` pulses for exactly one cycle, on the clock edge after the cycle in which the frame closes. The word then holds until the next close. Bit positions are: 19 over-max, 21 control, 22 interrupt, 23 seven-wire path, 24 alignment, 25 CRC, 26 overflow, 27 long, 29 parity, 30 good, 31 halted. Bits 20, 28 and 18..0 are zero. After reset, word, valid and irq are zero.
- R2: Bit 27 (long) is set when the frame's byte count exceeds `LONG_LIMIT` (1518), unless `long_en` is 1 in the closing cycle.
- R3: Bit 19 (over-max) is set when the byte count exceeds `max_len`, sampled in the closing cycle.
- R4: Bit 24 (alignment) is set only on a normal close with `dribble`=1 and `crc_ok`=0.
- R5: Bit 25 (CRC) is set on a normal close with `crc_ok`=0, or when `phy_err` was high in any cycle of the frame.
- R6: Bit 26 (overflow) is set if `byte_vld` and `fifo_full` were high together in any cycle of the frame. Bit 29 (parity) is set if `fifo_par_err` was high in any cycle of the frame.
- R7: Bit 21 is set if `ctl_frame` was high in any cycle of the frame. Bit 23 equals `path_7wire` in the closing cycle.
- R8: `halt_now`=1 or `rx_enable`=0 in an open frame closes it in that cycle with bit 31 set. `crc_ok` and `dribble` are then ignored.
- R9: Bit 30 (good) is set exactly when none of bits 19, 24, 25, 26, 27, 29, 31 is set. Bits 21 and 23 do not affect it.
- R10: Bit 22 is set when any of bits 19, 24, 25, 26, 27, 29, 31 is set, or when the frame is good and `good_en` is 1. `irq` equals bit 22 during the valid pulse and is 0 otherwise.
- R11: Error records clear when a new frame opens. Inputs seen while no frame is open have no effect.
- R12: The byte counter saturates at 2^CNT_W-1 instead of wrapping, so very long frames still report long and over-max.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Opens a frame in this cycle |
| byte_vld | input | 1 | One received byte in this cycle |
| eof | input | 1 | Normal end of frame in this cycle |
| dribble | input | 1 | Frame bit length not a multiple of eight (at eof) |
| crc_ok | input | 1 | CRC check passed (at eof) |
| phy_err | input | 1 | PHY receive error |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_par_err | input | 1 | Receive FIFO parity fault |
| ctl_frame | input | 1 | Frame recognised as a MAC control frame |
| path_7wire | input | 1 | 1 = seven-wire 10 Mb/s path, 0 = MII |
| long_en | input | 1 | Accept long frames without flagging |
| good_en | input | 1 | Interrupt on good frames |
| rx_enable | input | 1 | Receive enable; 0 aborts an open frame |
| halt_now | input | 1 | Immediate halt; aborts an open frame |
| max_len | input | CNT_W | Programmable maximum frame size in bytes |
| status_word | output | 32 | Descriptor status word |
| status_vld | output | 1 | One-cycle strobe for a new status word |
| irq | output | 1 | Interrupt request pulse |

## Verification
The main sweep closes short frames under every combination of dribble, CRC result, PHY error, overflow, parity, control, path, long-enable and good-enable. This separates alignment from plain CRC failures and control/path bits from error bits. It also shows where good-enable alone decides the interrupt. A second sweep aborts frames through both halt inputs, showing that end-of-frame checks are skipped while sticky errors survive. Lengths around 1518 and around `max_len` locate both thresholds to the byte. A frame longer than the counter range tells saturation apart from wrap-around. Events injected between frames must leave a later clean frame good.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int STW_W      = 32;
  localparam int B_OVMAX    = 19;
  localparam int B_CTL      = 21;
  localparam int B_INT      = 22;
  localparam int B_PATH7    = 23;
  localparam int B_ALIGN    = 24;
  localparam int B_CRC      = 25;
  localparam int B_OVF      = 26;
  localparam int B_LONG     = 27;
  localparam int B_PAR      = 29;
  localparam int B_GOOD     = 30;
  localparam int B_HALT     = 31;

  // order of sticky record bits
  localparam int STK_PHY = 0;
  localparam int STK_OVF = 1;
  localparam int STK_PAR = 2;
  localparam int STK_CTL = 3;
  localparam int STK_N   = 4;
endpackage

// File: rtl/rfs_byte_cnt.sv
module rfs_byte_cnt #(
  parameter int CNT_W      = 12,
  parameter int LONG_LIMIT = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] max_len,
  output logic             long_hit,
  output logic             ovmax_hit
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;

  always_comb begin
    cnt_base = clr ? '0 : cnt_q;
    cnt_d    = cnt_base;
    if (inc && (cnt_base != CNT_TOP)) cnt_d = cnt_base + 1'b1;
  end

  assign long_hit  = cnt_d > LONG_L;
  assign ovmax_hit = cnt_d > max_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && en && !clr) |=> (cnt_q == CNT_TOP));
endmodule

// File: rtl/rfs_sticky.sv
module rfs_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] cur
);
  logic [N-1:0] rec_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign cur[g] = (clr ? 1'b0 : rec_q[g]) | set[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rec_q[g] <= 1'b0;
      else if (en) rec_q[g] <= cur[g];
    end

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && rec_q[g]) |=> rec_q[g]);
  end
endmodule

// File: rtl/rfs_status_pack.sv
module rfs_status_pack
  import rfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close,
  input  logic             halted,
  input  logic             crc_bad_eof,
  input  logic             align_eof,
  input  logic [STK_N-1:0] seen,
  input  logic             long_hit,
  input  logic             ovmax_hit,
  input  logic             path_7w,
  input  logic             long_en,
  input  logic             good_en,
  output logic [STW_W-1:0] word,
  output logic             vld,
  output logic             irq
);
  logic             e_long, e_crc, any_err, good, intr;
  logic [STW_W-1:0] word_d, word_q;
  logic             vld_q, irq_q;

  always_comb begin
    e_long  = long_hit & ~long_en;
    e_crc   = crc_bad_eof | seen[STK_PHY];
    any_err = ovmax_hit | align_eof | e_crc | seen[STK_OVF] |
              e_long | seen[STK_PAR] | halted;
    good    = ~any_err;
    intr    = any_err | (good & good_en);

    word_d           = '0;
    word_d[B_OVMAX]  = ovmax_hit;
    word_d[B_CTL]    = seen[STK_CTL];
    word_d[B_INT]    = intr;
    word_d[B_PATH7]  = path_7w;
    word_d[B_ALIGN]  = align_eof;
    word_d[B_CRC]    = e_crc;
    word_d[B_OVF]    = seen[STK_OVF];
    word_d[B_LONG]   = e_long;
    word_d[B_PAR]    = seen[STK_PAR];
    word_d[B_GOOD]   = good;
    word_d[B_HALT]   = halted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      vld_q <= close;
      irq_q <= close & intr;
      if (close) word_q <= word_d;
    end
  end

  assign word = word_q;
  assign vld  = vld_q;
  assign irq  = irq_q;

  // R9
  good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && word_q[B_GOOD]) |-> !(word_q[B_OVMAX] | word_q[B_ALIGN] | word_q[B_CRC] |
      word_q[B_OVF] | word_q[B_LONG] | word_q[B_PAR] | word_q[B_HALT]));

  // R4
  align_has_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && word_q[B_ALIGN]) |-> word_q[B_CRC]);

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (vld_q && word_q[B_INT]));
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rfs_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LONG_LIMIT = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  input  logic             eof,
  input  logic             dribble,
  input  logic             crc_ok,
  input  logic             phy_err,
  input  logic             fifo_full,
  input  logic             fifo_par_err,
  input  logic             ctl_frame,
  input  logic             path_7wire,
  input  logic             long_en,
  input  logic             good_en,
  input  logic             rx_enable,
  input  logic             halt_now,
  input  logic [CNT_W-1:0] max_len,
  output logic [31:0]      status_word,
  output logic             status_vld,
  output logic             irq
);
  logic             in_frame_q, in_frame_d;
  logic             active, abort, close, norm_end;
  logic             crc_bad_eof, align_eof;
  logic [STK_N-1:0] ev_set, seen;
  logic             long_hit, ovmax_hit;

  always_comb begin
    active     = in_frame_q | sof;
    abort      = active & (~rx_enable | halt_now);
    close      = active & (eof | abort);
    norm_end   = close & ~abort;
    in_frame_d = active & ~close;

    crc_bad_eof = norm_end & ~crc_ok;
    align_eof   = norm_end & ~crc_ok & dribble;

    ev_set          = '0;
    ev_set[STK_PHY] = active & phy_err;
    ev_set[STK_OVF] = active & byte_vld & fifo_full;
    ev_set[STK_PAR] = active & fifo_par_err;
    ev_set[STK_CTL] = active & ctl_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= in_frame_d;
  end

  rfs_byte_cnt #(.CNT_W(CNT_W), .LONG_LIMIT(LONG_LIMIT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (active),
    .clr       (sof),
    .inc       (byte_vld),
    .max_len   (max_len),
    .long_hit  (long_hit),
    .ovmax_hit (ovmax_hit)
  );

  rfs_sticky #(.N(STK_N)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (active),
    .clr   (sof),
    .set   (ev_set),
    .cur   (seen)
  );

  rfs_status_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .close       (close),
    .halted      (abort),
    .crc_bad_eof (crc_bad_eof),
    .align_eof   (align_eof),
    .seen        (seen),
    .long_hit    (long_hit),
    .ovmax_hit   (ovmax_hit),
    .path_7w     (path_7wire),
    .long_en     (long_en),
    .good_en     (good_en),
    .word        (status_word),
    .vld         (status_vld),
    .irq         (irq)
  );

  // R1
  vld_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> status_vld);

  // R1
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !status_vld);

  // R8
  halt_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && halt_now) |=> (status_vld && status_word[B_HALT] && !status_word[B_ALIGN]));
endmodule

// File: tb/sim_rx_frame_status.sv
`timescale 1ns/1ps
module sim_rx_frame_status;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 0, byte_vld = 0, eof = 0, dribble = 0, crc_ok = 1, phy_err = 0;
  logic fifo_full = 0, fifo_par_err = 0, ctl_frame = 0, path_7wire = 0;
  logic long_en = 0, good_en = 0, rx_enable = 1, halt_now = 0;
  logic [CW-1:0] max_len = 100;
  logic [31:0] status_word;
  logic status_vld, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_frame_status #(.CNT_W(CW), .LONG_LIMIT(1518)) u0 (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .eof(eof),
    .dribble(dribble), .crc_ok(crc_ok), .phy_err(phy_err), .fifo_full(fifo_full),
    .fifo_par_err(fifo_par_err), .ctl_frame(ctl_frame), .path_7wire(path_7wire),
    .long_en(long_en), .good_en(good_en), .rx_enable(rx_enable), .halt_now(halt_now),
    .max_len(max_len), .status_word(status_word), .status_vld(status_vld), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sof = 0; byte_vld = 0; eof = 0; dribble = 0; crc_ok = 1; phy_err = 0;
    fifo_full = 0; fifo_par_err = 0; ctl_frame = 0; halt_now = 0; rx_enable = 1;
  endtask

  function automatic logic [31:0] model(input int len, input bit drb, input bit ck,
      input bit phy, input bit ful, input bit par, input bit ctl, input bit pth,
      input bit le, input bit ge, input int halt, input int ml);
    logic [31:0] w;
    int cnt;
    bit e_long, e_max, e_al, e_crc, errs, good;
    cnt    = (len > 4095) ? 4095 : len;
    e_long = (cnt > 1518) && !le;
    e_max  = cnt > ml;
    e_al   = (halt == 0) && drb && !ck;
    e_crc  = ((halt == 0) && !ck) || phy;
    errs   = e_long | e_max | e_al | e_crc | ful | par | (halt != 0);
    good   = !errs;
    w = '0;
    w[19] = e_max; w[21] = ctl; w[22] = errs | (good & ge); w[23] = pth;
    w[24] = e_al;  w[25] = e_crc; w[26] = ful; w[27] = e_long;
    w[29] = par;   w[30] = good; w[31] = (halt != 0);
    return w;
  endfunction

  // halt: 0 normal eof, 1 halt_now, 2 rx_enable dropped
  task automatic frame(input string req, input int len, input bit drb, input bit ck,
      input bit phy, input bit ful, input bit par, input bit ctl, input bit pth,
      input bit le, input bit ge, input int halt, input int ml);
    logic [31:0] exp;
    int pi;
    pi = (len > 1) ? 1 : 0;
    exp = model(len, drb, ck, phy, ful, par, ctl, pth, le, ge, halt, ml);
    for (int i = 0; i < len; i++) begin
      sof          = (i == 0);
      byte_vld     = 1'b1;
      phy_err      = phy && (i == pi);
      fifo_full    = ful && (i == pi);
      fifo_par_err = par && (i == pi);
      ctl_frame    = ctl && (i == pi);
      path_7wire   = pth; long_en = le; good_en = ge; max_len = CW'(ml);
      crc_ok       = ck;
      dribble      = (i == len - 1) ? drb : 1'b0;
      eof          = (i == len - 1) && (halt == 0);
      halt_now     = (i == len - 1) && (halt == 1);
      rx_enable    = !((i == len - 1) && (halt == 2));
      @(negedge clk);
    end
    idle_inputs();
    chk({req, " vld"}, 32'(status_vld), 32'd1);
    chk({req, " word"}, status_word, exp);
    chk({req, " irq R10"}, 32'(irq), 32'(exp[22]));
    @(negedge clk);
    chk("R1 pulse ends", 32'(status_vld), 32'd0);
    chk("R1 word holds", status_word, exp);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset word", status_word, 32'd0);
    chk("R1 reset vld", 32'(status_vld), 32'd0);
    chk("R1 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7 R9 R10: all flag combinations on short frames
    for (int m = 0; m < 512; m++)
      frame("R9 sweep", 4, m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7], m[8], 0, 100);

    // R8: aborts by either control, with sticky flags
    for (int h = 1; h < 3; h++)
      for (int m = 0; m < 64; m++)
        frame("R8 abort", 3, m[0], m[1], m[2], m[3], m[4], m[5], 0, 0, 1, h, 100);

    // R2 R3: thresholds
    for (int l = 1518; l < 1520; l++)
      for (int le = 0; le < 2; le++)
        for (int ml = 1517; ml < 1520; ml++)
          frame("R2 R3 length", l, 0, 1, 0, 0, 0, 0, 0, le, 1, 0, ml);

    // single-byte frame (sof and eof together)
    frame("R1 one byte", 1, 0, 1, 0, 0, 0, 1, 1, 0, 1, 0, 100);

    // R12: saturation beyond counter range
    frame("R12 sat max", 5000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4094);
    frame("R12 sat top", 5000, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 4095);

    // R11: events between frames are ignored
    frame("R11 dirty", 4, 1, 0, 1, 1, 1, 1, 0, 0, 0, 0, 100);
    for (int i = 0; i < 4; i++) begin
      phy_err = 1; fifo_full = 1; byte_vld = 1; fifo_par_err = 1; ctl_frame = 1;
      eof = (i == 2); halt_now = (i == 3);
      @(negedge clk);
      chk("R11 no vld outside frame", 32'(status_vld), 32'd0);
    end
    idle_inputs();
    @(negedge clk);
    frame("R11 clean after", 10, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 100);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule